// File: doc/BRIEF.md
# Macroblock Edge Mask Generator

This block finds the edge pixels of one square block of pixels ahead of an edge-driven motion search. After a start pulse the block takes in the pixels as three parallel row streams: the row above, the row itself and the row below. Each accepted cycle carries one pixel per stream, and columns arrive left to right, top row first. For every pixel it forms a 3x3 high-pass magnitude. At the block's border, missing neighbours are replaced by the nearest in-block pixel. The magnitudes go into an internal gradient store, while the largest and smallest values are tracked.

When the whole block has been loaded, the smallest and largest magnitudes give a threshold that adapts to the block. A second pass then reads every stored magnitude and compares it with the threshold to build an N x N edge mask. From the mask, the block counts how many columns hold at least one edge pixel and how many rows do. The wider of the two spans picks the scan order for the matching stage that follows. The results are announced with a one-cycle pulse, and the mask is then streamed out one row per cycle.

Top module: `mb_edge_mask`

## Requirements
- R1: The magnitude of a pixel is |8*centre - (sum of its eight neighbours)|. The factor of eight is formed by a 3-bit left shift, and the result is kept as an unsigned GRAD_W-bit value.
- R2: Out-of-block neighbours are replaced by replication. On row 0, `pix_above` is ignored and the current row stands in for it. On row N-1, `pix_below` is ignored in the same way. In column 0 and column N-1, the missing side is replaced by the centre column of each of the three rows.
- R3: The threshold is min + ((max - min) >> 1) over all magnitudes of the block, and a pixel is an edge when its magnitude is greater than or equal to the threshold. A flat block therefore gives an all-ones mask, and the mask is never empty.
- R4: `mask_valid` is high for exactly one cycle. In each of the N cycles that follow, `word_valid` is high and `mask_word` carries row k, with k running from 0 to N-1. Bit c of the word is column c.
- R5: `span_x` is the number of columns that contain at least one edge pixel, and `span_y` is the number of such rows. Both are updated together with the `mask_valid` pulse and hold their values until the next pulse.
- R6: `scan_col` is 1 (column-wise scan) when `span_x` > `span_y`, and 0 (row-wise scan) otherwise, including when the two are equal.
- R7: `busy` rises in the cycle after an accepted `start` and stays high until the cycle after the last mask word. A `start` that arrives while `busy` is high is ignored.
- R8: A pixel triple is consumed only in a cycle where `in_valid` is high during loading, and cycles with `in_valid` low stall the load. `in_valid` has no effect while idle, once all N*N triples have arrived, or after loading has finished.
- R9: While `rst_n` is low, and immediately after it rises, `busy`, `mask_valid` and `word_valid` are 0, and so are `span_x`, `span_y` and `scan_col`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start-of-block pulse, accepted only while idle |
| in_valid | input | 1 | Pixel triple on the three row inputs is valid |
| pix_above | input | PIX_W | Pixel of the row above the current row |
| pix_row | input | PIX_W | Pixel of the current row |
| pix_below | input | PIX_W | Pixel of the row below the current row |
| busy | output | 1 | Block is being loaded, evaluated or read out |
| mask_valid | output | 1 | One-cycle pulse: spans and scan choice are valid |
| span_x | output | $clog2(N+1) | Count of columns holding an edge pixel |
| span_y | output | $clog2(N+1) | Count of rows holding an edge pixel |
| scan_col | output | 1 | 1 = column-wise scan, 0 = row-wise scan |
| word_valid | output | 1 | `mask_word` carries one mask row |
| mask_word | output | N | Edge mask row, bit c is column c |

## Verification
Some properties are checked on every cycle. These cover the shape of the result handshake: the pulse width of `mask_valid`, the N-word stream that directly follows it, and `busy` covering both. They also cover the capture of `start` while idle, that the spans never change outside the pulse and are never zero, and that the scan choice agrees with the spans. Only the bench's scenarios can show that the mask bits themselves are right. For this, known images are compared against an independent model: a flat block, isolated dots in the interior and in a corner, vertical and horizontal lines, and random images. The same scenarios also check that junk on the out-of-block row inputs, stalls on `in_valid`, a stray `start` during loading and a reset in the middle of a block leave the result unchanged or clean.

// File: rtl/mbem_pkg.sv
package mbem_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_THR,
      ST_SCAN,
      ST_REPORT,
      ST_STREAM,
      ST_DONE
   } mbem_state_e;

   localparam logic SCAN_ROWWISE = 1'b0;
   localparam logic SCAN_COLWISE = 1'b1;

endpackage

// File: rtl/mbem_grad_filter.sv
// 3x3 high-pass magnitude: |8*centre - sum of eight neighbours|.
// Tap index 0 = left, 1 = centre, 2 = right.
module mbem_grad_filter #(
   parameter int PIX_W  = 8,
   parameter int GRAD_W = 12
) (
   input  logic [2:0][PIX_W-1:0] row_up,
   input  logic [2:0][PIX_W-1:0] row_mid,
   input  logic [2:0][PIX_W-1:0] row_dn,
   output logic [GRAD_W-1:0]     grad
);
   localparam int SUM_W = PIX_W + 4;

   if (GRAD_W < PIX_W + 3) begin : g_bad_width
      $error("mbem_grad_filter: GRAD_W must hold 8x a full-scale pixel");
   end

   logic [SUM_W-1:0] nb_sum;
   logic [SUM_W-1:0] ctr_x8;
   logic [SUM_W-1:0] mag;

   always_comb begin
      nb_sum = SUM_W'(row_up[0]) + SUM_W'(row_up[1]) + SUM_W'(row_up[2])
             + SUM_W'(row_mid[0]) + SUM_W'(row_mid[2])
             + SUM_W'(row_dn[0]) + SUM_W'(row_dn[1]) + SUM_W'(row_dn[2]);
      ctr_x8 = SUM_W'(row_mid[1]) << 3;
      if (ctr_x8 >= nb_sum) mag = ctr_x8 - nb_sum;
      else                  mag = nb_sum - ctr_x8;
      grad = GRAD_W'(mag);
   end
endmodule

// File: rtl/mbem_line_window.sv
// Two-deep delay line for one row stream; left tap can be replaced by
// the centre for the left border column.
module mbem_line_window #(
   parameter int PIX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift,
   input  logic [PIX_W-1:0] din,
   input  logic             dup_left,
   output logic [PIX_W-1:0] left_o,
   output logic [PIX_W-1:0] ctr_o
);
   logic [PIX_W-1:0] lft_q, ctr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lft_q <= '0;
         ctr_q <= '0;
      end else if (shift) begin
         lft_q <= ctr_q;
         ctr_q <= din;
      end
   end

   assign ctr_o  = ctr_q;
   assign left_o = dup_left ? ctr_q : lft_q;
endmodule

// File: rtl/mbem_grad_store.sv
// Gradient memory with running extremes.
module mbem_grad_store #(
   parameter int GRAD_W = 12,
   parameter int DEPTH  = 256,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [GRAD_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [GRAD_W-1:0] rdata,
   output logic [GRAD_W-1:0] gmax,
   output logic [GRAD_W-1:0] gmin
);
   if (DEPTH < 4) begin : g_bad_depth
      $error("mbem_grad_store: DEPTH too small");
   end

   logic [GRAD_W-1:0] mem [DEPTH];
   logic [GRAD_W-1:0] max_q, min_q;

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         max_q <= '0;
         min_q <= '1;
      end else if (clr) begin
         max_q <= '0;
         min_q <= '1;
      end else if (we) begin
         if (wdata > max_q) max_q <= wdata;
         if (wdata < min_q) min_q <= wdata;
      end
   end

   assign rdata = mem[raddr];
   assign gmax  = max_q;
   assign gmin  = min_q;
endmodule

// File: rtl/mbem_mask_eval.sv
// Adaptive threshold, edge mask, row/column hit vectors and span counts.
module mbem_mask_eval #(
   parameter int N      = 16,
   parameter int GRAD_W = 12,
   localparam int AW    = $clog2(N*N),
   localparam int SPW   = $clog2(N+1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              thr_load,
   input  logic [GRAD_W-1:0] gmax,
   input  logic [GRAD_W-1:0] gmin,
   input  logic              cmp_en,
   input  logic [AW-1:0]     cmp_idx,
   input  logic [GRAD_W-1:0] cmp_grad,
   output logic [N*N-1:0]    mask,
   output logic [SPW-1:0]    xspan,
   output logic [SPW-1:0]    yspan,
   output logic              col_scan
);
   logic [GRAD_W-1:0] thr_q;
   logic [N*N-1:0]    mask_q;
   logic [N-1:0]      row_hit, col_hit;
   logic [N-1:0]      col_bits [N];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_q  <= '0;
         mask_q <= '0;
      end else begin
         if (thr_load) thr_q <= gmin + ((gmax - gmin) >> 1);
         if (clr)         mask_q <= '0;
         else if (cmp_en) mask_q[cmp_idx] <= (cmp_grad >= thr_q);
      end
   end

   for (genvar r = 0; r < N; r++) begin : g_row
      assign row_hit[r] = |mask_q[r*N +: N];
   end

   for (genvar c = 0; c < N; c++) begin : g_col
      for (genvar r = 0; r < N; r++) begin : g_bit
         assign col_bits[c][r] = mask_q[r*N + c];
      end
      assign col_hit[c] = |col_bits[c];
   end

   always_comb begin
      xspan = '0;
      yspan = '0;
      for (int i = 0; i < N; i++) begin
         xspan = xspan + SPW'(col_hit[i]);
         yspan = yspan + SPW'(row_hit[i]);
      end
   end

   assign col_scan = (xspan > yspan) ? mbem_pkg::SCAN_COLWISE : mbem_pkg::SCAN_ROWWISE;
   assign mask     = mask_q;
endmodule

// File: rtl/mb_edge_mask.sv
module mb_edge_mask #(
   parameter int N      = 16,
   parameter int PIX_W  = 8,
   parameter int GRAD_W = 12,
   localparam int CW    = $clog2(N),
   localparam int AW    = $clog2(N*N),
   localparam int SPW   = $clog2(N+1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             in_valid,
   input  logic [PIX_W-1:0] pix_above,
   input  logic [PIX_W-1:0] pix_row,
   input  logic [PIX_W-1:0] pix_below,
   output logic             busy,
   output logic             mask_valid,
   output logic [SPW-1:0]   span_x,
   output logic [SPW-1:0]   span_y,
   output logic             scan_col,
   output logic             word_valid,
   output logic [N-1:0]     mask_word
);
   import mbem_pkg::*;

   if (N < 3) begin : g_bad_n
      $error("mb_edge_mask: N must be at least 3");
   end

   mbem_state_e     state_q;
   logic [CW-1:0]   col_q, row_q, tail_row_q, word_q;
   logic            all_in_q, tail_q;
   logic [AW-1:0]   scan_idx_q;

   logic            accept, main_calc, dup_left, we, clr, last_write;
   logic [CW-1:0]   gcol, grow;
   logic [AW-1:0]   waddr;
   logic [PIX_W-1:0] din   [3];
   logic [PIX_W-1:0] lft_t [3];
   logic [PIX_W-1:0] ctr_t [3];
   logic [2:0][2:0][PIX_W-1:0] taps;
   logic [GRAD_W-1:0] grad, rdata, gmax, gmin;
   logic [N*N-1:0]  mask_bits;
   logic [SPW-1:0]  xspan, yspan;
   logic            col_scan;

   // ---------------- load-side control ----------------
   assign accept     = (state_q == ST_LOAD) && in_valid && !all_in_q;
   assign main_calc  = accept && (col_q != '0);
   assign gcol       = tail_q ? CW'(N-1) : col_q - CW'(1);
   assign grow       = tail_q ? tail_row_q : row_q;
   assign dup_left   = !tail_q && (col_q == CW'(1));
   assign we         = main_calc || tail_q;
   assign waddr      = AW'(int'(grow) * N + int'(gcol));
   assign clr        = (state_q == ST_IDLE) && start;
   assign last_write = tail_q && (tail_row_q == CW'(N-1));

   // vertical border replication at the stream inputs
   assign din[0] = (row_q == '0)       ? pix_row : pix_above;
   assign din[1] = pix_row;
   assign din[2] = (row_q == CW'(N-1)) ? pix_row : pix_below;

   for (genvar l = 0; l < 3; l++) begin : g_line
      mbem_line_window #(.PIX_W(PIX_W)) u_win (
         .clk      (clk),
         .rst_n    (rst_n),
         .shift    (accept),
         .din      (din[l]),
         .dup_left (dup_left),
         .left_o   (lft_t[l]),
         .ctr_o    (ctr_t[l])
      );
      assign taps[l][0] = lft_t[l];
      assign taps[l][1] = ctr_t[l];
      assign taps[l][2] = tail_q ? ctr_t[l] : din[l];
   end

   mbem_grad_filter #(.PIX_W(PIX_W), .GRAD_W(GRAD_W)) u_filt (
      .row_up  (taps[0]),
      .row_mid (taps[1]),
      .row_dn  (taps[2]),
      .grad    (grad)
   );

   mbem_grad_store #(.GRAD_W(GRAD_W), .DEPTH(N*N)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .we    (we),
      .waddr (waddr),
      .wdata (grad),
      .raddr (scan_idx_q),
      .rdata (rdata),
      .gmax  (gmax),
      .gmin  (gmin)
   );

   mbem_mask_eval #(.N(N), .GRAD_W(GRAD_W)) u_eval (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .thr_load (state_q == ST_THR),
      .gmax     (gmax),
      .gmin     (gmin),
      .cmp_en   (state_q == ST_SCAN),
      .cmp_idx  (scan_idx_q),
      .cmp_grad (rdata),
      .mask     (mask_bits),
      .xspan    (xspan),
      .yspan    (yspan),
      .col_scan (col_scan)
   );

   // ---------------- sequencer ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         col_q      <= '0;
         row_q      <= '0;
         tail_row_q <= '0;
         all_in_q   <= 1'b0;
         tail_q     <= 1'b0;
         scan_idx_q <= '0;
         word_q     <= '0;
      end else begin
         tail_q <= 1'b0;
         case (state_q)
            ST_IDLE: if (start) begin
               state_q  <= ST_LOAD;
               col_q    <= '0;
               row_q    <= '0;
               all_in_q <= 1'b0;
            end
            ST_LOAD: begin
               if (accept) begin
                  tail_q     <= (col_q == CW'(N-1));
                  tail_row_q <= row_q;
                  if (col_q == CW'(N-1)) begin
                     col_q <= '0;
                     if (row_q == CW'(N-1)) all_in_q <= 1'b1;
                     else                   row_q    <= row_q + CW'(1);
                  end else begin
                     col_q <= col_q + CW'(1);
                  end
               end
               if (last_write) state_q <= ST_THR;
            end
            ST_THR: begin
               scan_idx_q <= '0;
               state_q    <= ST_SCAN;
            end
            ST_SCAN: begin
               scan_idx_q <= scan_idx_q + AW'(1);
               if (scan_idx_q == AW'(N*N-1)) state_q <= ST_REPORT;
            end
            ST_REPORT: begin
               word_q  <= '0;
               state_q <= ST_STREAM;
            end
            ST_STREAM: begin
               word_q <= word_q + CW'(1);
               if (word_q == CW'(N-1)) state_q <= ST_DONE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // ---------------- result outputs ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_valid <= 1'b0;
         word_valid <= 1'b0;
         span_x     <= '0;
         span_y     <= '0;
         scan_col   <= 1'b0;
         mask_word  <= '0;
      end else begin
         mask_valid <= (state_q == ST_REPORT);
         word_valid <= (state_q == ST_STREAM);
         if (state_q == ST_REPORT) begin
            span_x   <= xspan;
            span_y   <= yspan;
            scan_col <= col_scan;
         end
         if (state_q == ST_STREAM) mask_word <= mask_bits[int'(word_q)*N +: N];
      end
   end

   assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/mb_edge_mask_chk.sv
module mb_edge_mask_chk #(
   parameter int N   = 16,
   parameter int SPW = 5
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic           busy,
   input logic           mask_valid,
   input logic           word_valid,
   input logic [SPW-1:0] span_x,
   input logic [SPW-1:0] span_y,
   input logic           scan_col
);
   logic [SPW:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          run_q <= '0;
      else if (word_valid) run_q <= run_q + 1'b1;
      else                 run_q <= '0;
   end

   p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mask_valid |=> !mask_valid);
   p_words_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mask_valid |=> word_valid);
   p_word_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> (run_q < (SPW+1)'(N)));
   p_run_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(word_valid) |-> (run_q == (SPW+1)'(N)));
   p_busy_cover_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_valid || word_valid) |-> busy);
   p_start_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
   p_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mask_valid |-> (span_x != '0 && span_y != '0 &&
                      span_x <= SPW'(N) && span_y <= SPW'(N)));
   p_span_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_valid |-> ($stable(span_x) && $stable(span_y) && $stable(scan_col)));
   p_dir_rule_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mask_valid |-> (scan_col == (span_x > span_y)));
endmodule

bind mb_edge_mask mb_edge_mask_chk #(.N(N), .SPW(SPW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .busy       (busy),
   .mask_valid (mask_valid),
   .word_valid (word_valid),
   .span_x     (span_x),
   .span_y     (span_y),
   .scan_col   (scan_col)
);

// File: tb/mb_edge_mask_tb.sv
module mb_edge_mask_tb;
   localparam int N     = 16;
   localparam int PIX_W = 8;
   localparam int SPW   = $clog2(N+1);

   // pattern id [15:13], span_x [12:8], span_y [7:3], scan_col [2]
   localparam int NVEC = 7;
   localparam logic [15:0] VEC [NVEC] = '{
      {3'd0, 5'd16, 5'd16, 1'b0, 2'b00},   // flat block
      {3'd1, 5'd1,  5'd1,  1'b0, 2'b00},   // interior dot
      {3'd2, 5'd3,  5'd16, 1'b0, 2'b00},   // vertical line
      {3'd3, 5'd16, 5'd3,  1'b1, 2'b00},   // horizontal line
      {3'd4, 5'd1,  5'd1,  1'b0, 2'b00},   // corner dot
      {3'd5, 5'd3,  5'd1,  1'b1, 2'b00},   // three dots on a row
      {3'd6, 5'd2,  5'd2,  1'b0, 2'b00}    // two dots, tie
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, in_valid = 1'b0;
   logic [PIX_W-1:0] pix_above = '0, pix_row = '0, pix_below = '0;
   logic busy, mask_valid, word_valid, scan_col;
   logic [SPW-1:0] span_x, span_y;
   logic [N-1:0] mask_word;

   always #5 clk = ~clk;

   mb_edge_mask #(.N(N), .PIX_W(PIX_W), .GRAD_W(12)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
      .pix_above(pix_above), .pix_row(pix_row), .pix_below(pix_below),
      .busy(busy), .mask_valid(mask_valid), .span_x(span_x), .span_y(span_y),
      .scan_col(scan_col), .word_valid(word_valid), .mask_word(mask_word)
   );

   int tests = 0, fails = 0, cycles = 0;
   int img [N][N];
   logic [N-1:0] exp_word [N];
   logic [N-1:0] got_word [N];
   int exp_xs, exp_ys, exp_dir, got_xs, got_ys, got_dir, got_n;
   int lcg = 12345;

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++;
         $display("FAIL R7 watchdog: cycles=%0d expected < 150000", cycles);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int clampi(input int v);
      return (v < 0) ? 0 : ((v > N-1) ? N-1 : v);
   endfunction

   task automatic set_pattern(input int id);
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++) begin
            lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
            case (id)
               0: img[r][c] = 100;
               2: img[r][c] = (c == 7) ? 255 : 0;
               3: img[r][c] = (r == 3) ? 255 : 0;
               7: img[r][c] = (lcg >> 8) & 255;
               default: img[r][c] = 0;
            endcase
         end
      if (id == 1) img[5][9] = 200;
      if (id == 4) img[0][0] = 200;
      if (id == 5) begin img[8][2] = 200; img[8][7] = 200; img[8][12] = 200; end
      if (id == 6) begin img[2][1] = 200; img[12][14] = 200; end
   endtask

   // independent reference: clamped-index 3x3 magnitude, adaptive threshold
   task automatic model();
      int g [N][N];
      int mx, mn, thr, s;
      bit rowh [N];
      bit colh [N];
      mx = 0; mn = 1 << 30;
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++) begin
            s = 0;
            for (int dr = -1; dr <= 1; dr++)
               for (int dc = -1; dc <= 1; dc++)
                  if (dr != 0 || dc != 0) s += img[clampi(r+dr)][clampi(c+dc)];
            g[r][c] = 8*img[r][c] - s;
            if (g[r][c] < 0) g[r][c] = -g[r][c];
            if (g[r][c] > mx) mx = g[r][c];
            if (g[r][c] < mn) mn = g[r][c];
         end
      thr = mn + (mx - mn) / 2;
      for (int i = 0; i < N; i++) begin rowh[i] = 0; colh[i] = 0; end
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++) begin
            exp_word[r][c] = (g[r][c] >= thr);
            if (g[r][c] >= thr) begin rowh[r] = 1; colh[c] = 1; end
         end
      exp_xs = 0; exp_ys = 0;
      for (int i = 0; i < N; i++) begin exp_xs += colh[i]; exp_ys += rowh[i]; end
      exp_dir = (exp_xs > exp_ys) ? 1 : 0;
   endtask

   // feed one block; gap>0 inserts stall cycles, poke issues a stray start
   task automatic run_block(input int gap, input bit poke, input string req);
      bit seen;
      int bad_row;
      @(negedge clk); start = 1'b1; in_valid = 1'b0;
      @(negedge clk); start = 1'b0;
      check(busy === 1'b1, "R7", "busy after start", busy, 1);
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++) begin
            if (gap > 0 && ((r*N + c) % gap) == 0) begin
               in_valid = 1'b0; pix_row = 8'hEE; pix_above = 8'hEE; pix_below = 8'hEE;
               @(negedge clk);
            end
            in_valid  = 1'b1;
            pix_row   = PIX_W'(img[r][c]);
            pix_above = (r == 0)   ? 8'hA5 : PIX_W'(img[r-1][c]);
            pix_below = (r == N-1) ? 8'h5A : PIX_W'(img[r+1][c]);
            start     = (poke && r == 4 && c == 3);
            @(negedge clk);
         end
      start = 1'b0;
      pix_row = 8'hFF; pix_above = 8'hFF; pix_below = 8'hFF;   // R8 surplus ignored
      repeat (3) @(negedge clk);
      in_valid = 1'b0;
      seen = 0;
      for (int k = 0; k < 3000 && !seen; k++) begin
         if (mask_valid) seen = 1;
         else @(negedge clk);
      end
      check(seen, "R4", "mask_valid pulse seen", seen, 1);
      got_xs = span_x; got_ys = span_y; got_dir = scan_col;
      check(busy === 1'b1, "R7", "busy at mask_valid", busy, 1);
      got_n = 0;
      for (int k = 0; k < N + 1; k++) begin
         @(negedge clk);
         if (word_valid) begin
            if (got_n < N) got_word[got_n] = mask_word;
            got_n++;
         end
      end
      check(got_n == N, "R4", "mask word count", got_n, N);
      check(busy === 1'b0, "R7", "busy low after last word", busy, 0);
      bad_row = -1;
      for (int r = N-1; r >= 0; r--) if (got_word[r] !== exp_word[r]) bad_row = r;
      check(bad_row < 0, req, "mask row mismatch (row index)", bad_row, -1);
      if (bad_row >= 0)
         $display("  row %0d actual=%h expected=%h", bad_row, got_word[bad_row], exp_word[bad_row]);
      check(got_xs == exp_xs, "R5", "span_x", got_xs, exp_xs);
      check(got_ys == exp_ys, "R5", "span_y", got_ys, exp_ys);
      check(got_dir == exp_dir, "R6", "scan_col", got_dir, exp_dir);
   endtask

   initial begin
      // R9: reset state
      repeat (3) @(negedge clk);
      check(busy === 1'b0 && mask_valid === 1'b0 && word_valid === 1'b0, "R9",
            "control outputs in reset", {busy, mask_valid, word_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(span_x == 0 && span_y == 0 && scan_col == 0, "R9", "result outputs after reset",
            span_x + span_y + scan_col, 0);

      // R8: in_valid while idle does nothing
      in_valid = 1'b1; pix_row = 8'h77;
      repeat (4) @(negedge clk);
      check(busy === 1'b0, "R8", "in_valid while idle keeps busy low", busy, 0);
      in_valid = 1'b0;

      // table walk: hand-derived spans and scan choice plus model mask
      for (int v = 0; v < NVEC; v++) begin
         set_pattern(int'(VEC[v][15:13]));
         model();
         check(exp_xs == int'(VEC[v][12:8]) && exp_ys == int'(VEC[v][7:3]), "R5",
               "table spans agree with model", exp_xs*100 + exp_ys,
               int'(VEC[v][12:8])*100 + int'(VEC[v][7:3]));
         run_block(0, 1'b0, (v == 4) ? "R2" : ((v == 0) ? "R3" : "R1"));
         check(got_dir == int'(VEC[v][2]), "R6", "table scan_col", got_dir, int'(VEC[v][2]));
      end

      // R1/R8: random image with stalls on in_valid
      set_pattern(7); model();
      run_block(5, 1'b0, "R8");

      // R7: stray start during loading is ignored
      set_pattern(7); model();
      run_block(0, 1'b1, "R7");

      // R9: reset in the middle of loading, then a clean block
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0; in_valid = 1'b1; pix_row = 8'h33;
      repeat (20) @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b0;
      @(negedge clk);
      check(busy === 1'b0 && mask_valid === 1'b0 && word_valid === 1'b0, "R9",
            "mid-block reset clears control", {busy, mask_valid, word_valid}, 0);
      check(span_x == 0 && span_y == 0, "R9", "mid-block reset clears spans", span_x + span_y, 0);
      rst_n = 1'b1;
      set_pattern(7); model();
      run_block(3, 1'b0, "R1");

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule